// File: doc/BRIEF.md
# Unified Add/Subtract Unit with Carry and Overflow Status

This unit carries out every integer add and subtract variant of a 64-bit pipeline on one adder. It computes `(A xor I) + B + C`. A is the first register operand, which an invert flag can complement. B is picked from the second register operand, an immediate, constant zero or constant all-ones. C is picked from zero, one or the stored carry bit. Plain add, subtract-from, add/subtract extended, the add-minus-one forms and negate are all settings of these three selectors. Negate, for example, uses inverted A, B = 0 and C = 1.

Beside the 64-bit sum, the unit keeps a five-bit status register with five fields: carry out of the full word, carry out of the low half, signed overflow at full width, signed overflow at half width, and a sticky summary-overflow bit. The register is updated at the same clock edge that registers the result, so the next instruction reads the new carry with no stall. A record-form add yields a 4-bit condition field. A compare operation yields the same kind of field from a signed comparison of A against B. Both forms put the summary-overflow bit in the low position.

Top module: `addsub_unit`

## Requirements
- R1: For an add operation (`in_op`=0), `out_result` is `(in_inv_a ? ~in_a : in_a) + B + C` modulo 2^64.
- R2: `in_bsel` selects B as follows: 0 selects `in_b`, 1 selects `in_imm`, 2 selects zero and 3 selects all-ones.
- R3: `in_csel` selects C as follows: 0 selects zero, 1 selects one, 2 selects the stored carry `st_ca`, and 3 is treated as zero.
- R4: When `in_ca_en` is set on an add, `st_ca` takes the carry out of bit 63 and `st_ca32` takes the carry out of bit 31. When `in_ca_en` is clear, both keep their values.
- R5: When `in_ov_en` is set on an add, `st_ov` and `st_ov32` take the signed overflow of the sum at 64-bit and 32-bit width. When `in_ov_en` is clear, both keep their values.
- R6: An add with `in_ov_en` set that overflows at 64 bits sets `st_so`. `st_so` is cleared only by an explicit status write.
- R7: `st_wr` loads `st_wdata` into the status register, with bit 4 = SO, bit 3 = OV, bit 2 = OV32, bit 1 = CA and bit 0 = CA32. A write takes priority over an add issued in the same cycle.
- R8: An add issued in the cycle right after a carry-updating add sees the updated carry when `in_csel`=2.
- R9: A record-form add (`in_rec`=1) sets `cr_field` to {lt, gt, eq, so}. lt, gt and eq come from the signed 64-bit result. so is the SO value including this add's own overflow.
- R10: A compare (`in_op`=1) sets `cr_field` to {A<B, A>B, A==B, current SO}, using a signed comparison of `in_a` with the selected B. It leaves all status bits unchanged and does not raise `out_valid`.
- R11: After reset, all status bits, `out_valid` and `cr_valid` are 0.
- R12: Results, condition fields and status appear one clock after issue. `out_valid` is raised only for add operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_op | input | 1 | 0 = add, 1 = signed compare |
| in_a | input | 64 | First register operand |
| in_b | input | 64 | Second register operand |
| in_imm | input | 64 | Immediate operand |
| in_bsel | input | 2 | B source select |
| in_csel | input | 2 | Carry-in select |
| in_inv_a | input | 1 | Complement A |
| in_ca_en | input | 1 | Update CA and CA32 |
| in_ov_en | input | 1 | Update OV and OV32 and accumulate SO |
| in_rec | input | 1 | Record form: produce a condition field |
| st_wr | input | 1 | Explicit status write |
| st_wdata | input | 5 | Status write value |
| out_valid | output | 1 | Add result valid |
| out_result | output | 64 | Add result |
| cr_valid | output | 1 | Condition field valid |
| cr_field | output | 4 | {lt, gt, eq, so} |
| st_ca | output | 1 | Carry out of bit 63 |
| st_ca32 | output | 1 | Carry out of bit 31 |
| st_ov | output | 1 | 64-bit signed overflow |
| st_ov32 | output | 1 | 32-bit signed overflow |
| st_so | output | 1 | Sticky summary overflow |

## Verification
The hardest case to reach is a status write and an overflowing record-form add in the same cycle. There the condition field must carry the SO the add produced, while the register keeps the written value. The stimulus reaches it by first clearing SO with a lone write, then issuing the overflowing add together with a different write value. Back-to-back carry use is reached by issuing a carry-out add and an extended add in consecutive cycles with no idle cycle between them. Half-width overflow and carry without full-width ones come from operands at the 32-bit signed boundary.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    BSRC_REG  = 2'd0,
    BSRC_IMM  = 2'd1,
    BSRC_ZERO = 2'd2,
    BSRC_ONES = 2'd3
  } bsrc_e;

  typedef enum logic [1:0] {
    CSRC_ZERO  = 2'd0,
    CSRC_ONE   = 2'd1,
    CSRC_CARRY = 2'd2,
    CSRC_RSVD  = 2'd3
  } csrc_e;

  // bit order matches the explicit write port
  typedef struct packed {
    logic so;
    logic ov;
    logic ov32;
    logic ca;
    logic ca32;
  } stat_t;

  // signed overflow from operand and sum sign bits
  function automatic logic signed_ovf(input logic a_msb, input logic b_msb,
                                      input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // {lt, gt, eq, so} from a signed sign/zero pair
  function automatic logic [3:0] cond_pack(input logic neg, input logic zero,
                                           input logic so);
    return {neg, (!neg && !zero), zero, so};
  endfunction

endpackage

// File: rtl/addsub_bmux.sv
module addsub_bmux
  import addsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] reg_b,
  input  logic [W-1:0] imm,
  input  logic [1:0]   sel,
  output logic [W-1:0] b_out
);
  always_comb begin
    unique case (bsrc_e'(sel))
      BSRC_REG:  b_out = reg_b;
      BSRC_IMM:  b_out = imm;
      BSRC_ZERO: b_out = '0;
      default:   b_out = '1;
    endcase
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic         inv_a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         ca,
  output logic         ca32,
  output logic         ov,
  output logic         ov32
);
  localparam int H  = W / 2;
  localparam int HU = W - H;

  logic [W-1:0] aa;
  logic [H:0]   lo_sum;
  logic [HU:0]  hi_sum;

  assign aa     = inv_a ? ~a : a;
  assign lo_sum = {1'b0, aa[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
  assign hi_sum = {1'b0, aa[W-1:H]} + {1'b0, b[W-1:H]} + {{HU{1'b0}}, lo_sum[H]};

  assign sum  = {hi_sum[HU-1:0], lo_sum[H-1:0]};
  assign ca   = hi_sum[HU];
  assign ca32 = lo_sum[H];
  assign ov   = signed_ovf(aa[W-1], b[W-1], sum[W-1]);
  assign ov32 = signed_ovf(aa[H-1], b[H-1], sum[H-1]);
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         gt,
  output logic         eq
);
  assign lt = $signed(a) < $signed(b);
  assign gt = $signed(a) > $signed(b);
  assign eq = (a == b);
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  stat_t wr_val,
  input  logic  ins_en,
  input  logic  ca_en,
  input  logic  ov_en,
  input  logic  ca_new,
  input  logic  ca32_new,
  input  logic  ov_new,
  input  logic  ov32_new,
  output stat_t cur,
  output logic  so_ins
);
  stat_t nxt;

  // SO as seen by the issuing instruction
  assign so_ins = cur.so | (ins_en & ov_en & ov_new);

  always_comb begin
    nxt = cur;
    if (wr_en) begin
      nxt = wr_val;
    end else if (ins_en) begin
      if (ca_en) begin
        nxt.ca   = ca_new;
        nxt.ca32 = ca32_new;
      end
      if (ov_en) begin
        nxt.ov   = ov_new;
        nxt.ov32 = ov32_new;
        nxt.so   = so_ins;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_imm,
  input  logic [1:0]   in_bsel,
  input  logic [1:0]   in_csel,
  input  logic         in_inv_a,
  input  logic         in_ca_en,
  input  logic         in_ov_en,
  input  logic         in_rec,
  input  logic         st_wr,
  input  logic [4:0]   st_wdata,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         cr_valid,
  output logic [3:0]   cr_field,
  output logic         st_ca,
  output logic         st_ca32,
  output logic         st_ov,
  output logic         st_ov32,
  output logic         st_so
);
  // named internal events, also observed by the checker
  logic         add_fire;
  logic         cmp_fire;
  logic [W-1:0] b_val;
  logic         cin;
  logic [W-1:0] core_sum;
  logic         core_ca;
  logic         core_ca32;
  logic         core_ov;
  logic         core_ov32;
  logic         so_ins;
  logic         cmp_lt;
  logic         cmp_gt;
  logic         cmp_eq;
  logic [3:0]   cr_next;
  stat_t        stat;

  assign add_fire = in_valid && !in_op;
  assign cmp_fire = in_valid &&  in_op;

  addsub_bmux #(.W(W)) u_bmux (
    .reg_b (in_b),
    .imm   (in_imm),
    .sel   (in_bsel),
    .b_out (b_val)
  );

  always_comb begin
    unique case (csrc_e'(in_csel))
      CSRC_ONE:   cin = 1'b1;
      CSRC_CARRY: cin = stat.ca;
      default:    cin = 1'b0;
    endcase
  end

  addsub_core #(.W(W)) u_core (
    .a     (in_a),
    .inv_a (in_inv_a),
    .b     (b_val),
    .cin   (cin),
    .sum   (core_sum),
    .ca    (core_ca),
    .ca32  (core_ca32),
    .ov    (core_ov),
    .ov32  (core_ov32)
  );

  addsub_cmp #(.W(W)) u_cmp (
    .a  (in_a),
    .b  (b_val),
    .lt (cmp_lt),
    .gt (cmp_gt),
    .eq (cmp_eq)
  );

  addsub_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (st_wr),
    .wr_val   (stat_t'(st_wdata)),
    .ins_en   (add_fire),
    .ca_en    (in_ca_en),
    .ov_en    (in_ov_en),
    .ca_new   (core_ca),
    .ca32_new (core_ca32),
    .ov_new   (core_ov),
    .ov32_new (core_ov32),
    .cur      (stat),
    .so_ins   (so_ins)
  );

  always_comb begin
    if (cmp_fire) cr_next = {cmp_lt, cmp_gt, cmp_eq, stat.so};
    else          cr_next = cond_pack(core_sum[W-1], core_sum == '0, so_ins);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      cr_valid   <= 1'b0;
      cr_field   <= '0;
    end else begin
      out_valid <= add_fire;
      cr_valid  <= cmp_fire || (add_fire && in_rec);
      if (add_fire) out_result <= core_sum;
      if (cmp_fire || (add_fire && in_rec)) cr_field <= cr_next;
    end
  end

  assign st_ca   = stat.ca;
  assign st_ca32 = stat.ca32;
  assign st_ov   = stat.ov;
  assign st_ov32 = stat.ov32;
  assign st_so   = stat.so;
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       add_fire,
  input logic       cmp_fire,
  input logic       in_ov_en,
  input logic       core_ov,
  input logic       st_wr,
  input logic [4:0] st_wdata,
  input logic       out_valid,
  input logic       cr_valid,
  input logic [3:0] cr_field,
  input logic       st_ca,
  input logic       st_ca32,
  input logic       st_ov,
  input logic       st_ov32,
  input logic       st_so
);
  logic [4:0] stv;
  assign stv = {st_so, st_ov, st_ov32, st_ca, st_ca32};

  p_so_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_so && !st_wr |=> st_so);

  p_so_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    add_fire && in_ov_en && core_ov && !st_wr |=> st_so);

  p_ov_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    add_fire && in_ov_en && !st_wr |=> st_ov == $past(core_ov));

  p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> stv == $past(st_wdata));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !add_fire && !st_wr |=> $stable(stv));

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    add_fire |=> out_valid);

  p_cmp_no_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> !out_valid && cr_valid);

  p_cr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> $countones(cr_field[3:1]) == 1);

  p_cr_so_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid && !$past(st_wr) |-> cr_field[0] == st_so);
endmodule

bind addsub_unit addsub_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .add_fire  (add_fire),
  .cmp_fire  (cmp_fire),
  .in_ov_en  (in_ov_en),
  .core_ov   (core_ov),
  .st_wr     (st_wr),
  .st_wdata  (st_wdata),
  .out_valid (out_valid),
  .cr_valid  (cr_valid),
  .cr_field  (cr_field),
  .st_ca     (st_ca),
  .st_ca32   (st_ca32),
  .st_ov     (st_ov),
  .st_ov32   (st_ov32),
  .st_so     (st_so)
);

// File: tb/addsub_unit_tb_top.sv
`timescale 1ns/1ps
module addsub_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [63:0] in_a = '0, in_b = '0, in_imm = '0;
  logic [1:0]  in_bsel = '0, in_csel = '0;
  logic        in_inv_a = 1'b0, in_ca_en = 1'b0, in_ov_en = 1'b0, in_rec = 1'b0;
  logic        st_wr = 1'b0;
  logic [4:0]  st_wdata = '0;
  logic        out_valid, cr_valid;
  logic [63:0] out_result;
  logic [3:0]  cr_field;
  logic        st_ca, st_ca32, st_ov, st_ov32, st_so;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addsub_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .in_bsel(in_bsel),
    .in_csel(in_csel), .in_inv_a(in_inv_a), .in_ca_en(in_ca_en),
    .in_ov_en(in_ov_en), .in_rec(in_rec), .st_wr(st_wr), .st_wdata(st_wdata),
    .out_valid(out_valid), .out_result(out_result), .cr_valid(cr_valid),
    .cr_field(cr_field), .st_ca(st_ca), .st_ca32(st_ca32), .st_ov(st_ov),
    .st_ov32(st_ov32), .st_so(st_so)
  );

  typedef struct {
    bit          has_res;
    logic [63:0] res;
    bit          has_cr;
    logic [3:0]  cr;
    logic [4:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [4:0] m_fl = '0;  // {so, ov, ov32, ca, ca32}

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: computes expectation independently and pushes it
  task automatic drive(input bit vld, input bit op, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] imm,
                       input logic [1:0] bs, input logic [1:0] cs,
                       input bit inv, input bit cae, input bit ove, input bit rec,
                       input bit wr, input logic [4:0] wd, input string tag);
    logic [63:0] aa, bv, s, cx;
    logic [64:0] full;
    logic        cin, ca, ca32, ov, ov32, so_i;
    logic [4:0]  nfl;
    exp_t        e;
    aa = inv ? ~a : a;
    case (bs)
      2'd0: bv = b;
      2'd1: bv = imm;
      2'd2: bv = '0;
      default: bv = '1;
    endcase
    case (cs)
      2'd1: cin = 1'b1;
      2'd2: cin = m_fl[1];
      default: cin = 1'b0;
    endcase
    full = {1'b0, aa} + {1'b0, bv} + {64'd0, cin};
    s    = full[63:0];
    cx   = aa ^ bv ^ s;       // carry into each bit position
    ca   = full[64];
    ca32 = cx[32];
    ov   = cx[63] ^ full[64];
    ov32 = cx[31] ^ cx[32];
    so_i = m_fl[4] | (ove & ov);
    nfl  = m_fl;
    if (vld && !op) begin
      if (cae) begin nfl[1] = ca; nfl[0] = ca32; end
      if (ove) begin nfl[3] = ov; nfl[2] = ov32; nfl[4] = so_i; end
    end
    if (wr) nfl = wd;
    e.has_res = vld && !op;
    e.res     = s;
    e.has_cr  = vld && (op || rec);
    if (op) e.cr = {$signed(a) < $signed(bv), $signed(a) > $signed(bv), a == bv, m_fl[4]};
    else    e.cr = {s[63], !s[63] && (s != 0), s == 0, so_i};
    e.fl  = nfl;
    e.tag = tag;
    m_fl  = nfl;
    @(negedge clk);
    in_valid = vld; in_op = op; in_a = a; in_b = b; in_imm = imm;
    in_bsel = bs; in_csel = cs; in_inv_a = inv; in_ca_en = cae;
    in_ov_en = ove; in_rec = rec; st_wr = wr; st_wdata = wd;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; st_wr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: sample shortly after the edge that registers each item
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(out_valid == e.has_res, e.tag, "out_valid", 64'(out_valid), 64'(e.has_res));
        if (e.has_res) check(out_result == e.res, e.tag, "result", out_result, e.res);
        check(cr_valid == e.has_cr, e.tag, "cr_valid", 64'(cr_valid), 64'(e.has_cr));
        if (e.has_cr) check(cr_field == e.cr, e.tag, "cr_field", 64'(cr_field), 64'(e.cr));
        check({st_so, st_ov, st_ov32, st_ca, st_ca32} == e.fl, e.tag, "status",
              64'({st_so, st_ov, st_ov32, st_ca, st_ca32}), 64'(e.fl));
      end else begin
        check(!out_valid && !cr_valid, "R12", "idle valid",
              64'({out_valid, cr_valid}), 64'd0);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check({st_so, st_ov, st_ov32, st_ca, st_ca32} == 5'd0, "R11", "reset status",
          64'({st_so, st_ov, st_ov32, st_ca, st_ca32}), 64'd0);
    check(!out_valid && !cr_valid, "R11", "reset valids", 64'({out_valid, cr_valid}), 64'd0);
    rst_n = 1'b1;
    idle(1);
    //     vld op a       b     imm    bs  cs  inv cae ove rec wr wd
    drive(1, 0, 64'd5,  64'd7, 0,     0,  0,  0,  0,  0,  1,  0, 0, "R1_R9 add reg");
    drive(1, 0, 64'd10, 64'd3, 0,     0,  1,  1,  1,  0,  1,  0, 0, "R1_R3 subtract");
    drive(1, 0, 64'd100, 0, 64'h20,   1,  0,  0,  0,  0,  0,  0, 0, "R2 imm");
    drive(1, 0, 64'd5,  0,     0,     2,  1,  1,  0,  0,  1,  0, 0, "R2 negate");
    drive(1, 0, ONES,   64'd1, 0,     0,  0,  0,  1,  0,  1,  0, 0, "R4 carry out");
    drive(1, 0, 64'd3,  64'd4, 0,     0,  2,  0,  1,  0,  0,  0, 0, "R8 back-to-back CA");
    drive(1, 0, 64'd9,  0,     0,     3,  2,  0,  0,  0,  0,  0, 0, "R2_R3 add minus one");
    drive(1, 0, 64'hFFFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 0,  0,  0, 0, "R4 ca_en clear");
    drive(1, 0, 64'hFFFF_FFFF, 64'd1, 0, 0, 0, 0, 1, 0,  0,  0, 0, "R4 half carry");
    drive(1, 0, 64'd1,  64'd1, 0,     0,  3,  0,  0,  0,  0,  0, 0, "R3 reserved csel");
    drive(1, 0, MAXP,   64'd1, 0,     0,  0,  0,  0,  1,  1,  0, 0, "R5_R6 ov64");
    drive(1, 0, 64'h7FFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 1,  1,  0, 0, "R5_R6 ov32 only");
    drive(1, 0, 64'd2,  64'd2, 0,     0,  0,  0,  0,  0,  0,  0, 0, "R5 ov_en clear");
    drive(1, 1, -64'sd3, 64'd2, 0,    0,  0,  0,  1,  1,  0,  0, 0, "R10 compare lt");
    drive(1, 1, 64'h20, 0, 64'h20,    1,  0,  0,  0,  0,  0,  0, 0, "R10 compare eq imm");
    drive(0, 0, 0,      0,     0,     0,  0,  0,  0,  0,  0,  1, 5'd0, "R7 write clear");
    drive(1, 0, MAXP,   64'd1, 0,     0,  0,  0,  1,  1,  1,  1, 5'b00010, "R7 write wins");
    drive(1, 1, 64'd5,  64'd5, 0,     0,  0,  0,  0,  0,  0,  0, 0, "R10 compare eq");
    drive(1, 1, 64'd9,  64'd5, 0,     0,  0,  0,  0,  0,  0,  0, 0, "R10 compare gt");
    drive(1, 0, ONES,   ONES,  0,     0,  2,  0,  1,  1,  1,  0, 0, "R8_R12 extended");
    idle(4);
    finish_run();
  end
endmodule